// File: doc/BRIEF.md
# Smart Card Interface Host Control and Interrupt Logic

This block sits between a host controller's control bus and the activation sequencer of a smart card interface. It samples the host's control inputs while the chip-select is high and freezes them while it is low, so several interfaces can share one set of control wires. While deselected it also turns off the driver of the interrupt line and stops passing data on the host-side data lines. Two card-presence switch inputs are synchronised and merged into one card-present signal. One switch reports presence with a high level and the other with a low level.

The active-low interrupt line has two meanings. Outside a card session it reports card presence. Inside a session it drops on any fault or on card removal, and stays low until the host releases the activate command. The block also handles power-down requests, which are accepted only outside a session. It runs a settling window after reset and after power-down exit, and it qualifies the falling edge of the activate command before handing a one-cycle start pulse to the sequencer.

Top module: `scif_host_ctrl`

## Requirements
- R1: While `cs` is 1, every latched control output takes the value of its input one clock later. While `cs` is 0, the latched controls keep their values.
- R2: `int_oe` and `host_dat_en` equal `cs`. A value of 0 means the interrupt line is not driven and the host data lines are released.
- R3: Card presence is `pres_hi` OR NOT `pres_lo_n`, each seen through a two-flop synchroniser. Outside a session and outside power-down, `int_n` is 1 only when a card is present and the settling window has ended. `sess_fault` has no effect on `int_n` outside a session.
- R4: Inside a session, `sess_fault` = 1 or loss of card presence drives `int_n` and `sess_run` to 0 in the same cycle. Both stay 0 while the latched activate command stays 0.
- R5: Power-down is entered only when the latched power-down request is 1, the latched activate command is 1 and no session is open. A request made during a session has no effect on `pd_state`.
- R6: In power-down, `int_n` follows card presence.
- R7: A settling window of `STAB_CYCLES` cycles follows reset and each power-down exit. With a card present, `int_n` stays 0 during the window and rises when it ends.
- R8: `act_start` is a one-cycle pulse on a 1-to-0 change of the latched activate command. The pulse occurs only when a card is present, the block is not in power-down, the settling window has ended and no session is open. An edge that fails these conditions is discarded, and a session needs a fresh edge. A pulse opens a session: `sess_run` is 1 in the next cycle.
- R9: A latched activate command of 1 closes the session and clears any held fault.
- R10: After reset, the latched activate command is 1 and the other latched controls, `pd_state`, `act_start` and `sess_run` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, 1 = controls pass through |
| act_n | input | 1 | Activate command, active low |
| rst_req | input | 1 | Card reset request |
| volt_sel | input | 1 | Card voltage select |
| div_sel | input | 2 | Card clock divide select |
| sync_mode | input | 1 | Synchronous card mode select |
| pd_req | input | 1 | Power-down request |
| pres_hi | input | 1 | Presence switch, active high |
| pres_lo_n | input | 1 | Presence switch, active low |
| sess_fault | input | 1 | Fault flag from the protection logic |
| lat_act_n | output | 1 | Latched activate command |
| lat_rst_req | output | 1 | Latched reset request |
| lat_volt_sel | output | 1 | Latched voltage select |
| lat_div_sel | output | 2 | Latched divide select |
| lat_sync_mode | output | 1 | Latched mode select |
| act_start | output | 1 | Qualified activate pulse to the sequencer |
| sess_run | output | 1 | Session open and free of faults |
| int_n | output | 1 | Interrupt/status value, active low |
| int_oe | output | 1 | Output enable for the interrupt line |
| host_dat_en | output | 1 | Host data line pass enable |
| pd_state | output | 1 | Power-down state |

## Verification
The assertions assume that `sess_fault` and all control inputs are synchronous to `clk`, and that only the two presence switches may change asynchronously. The stimulus drives every input one nanosecond after a rising edge, so it stays inside that assumption. Random toggles of the activate command, the power-down request, the switches and the fault flag are weighted to be rare. This lets sessions open, run, fault and close many times. Chip-select drops out about one cycle in eight, so frozen and passing controls are both exercised.

// File: rtl/scif_hc_pkg.sv
package scif_hc_pkg;
  typedef struct packed {
    logic       act_n;
    logic       rst_req;
    logic       volt_sel;
    logic [1:0] div_sel;
    logic       sync_mode;
    logic       pd_req;
  } hc_ctl_t;

  localparam int CTL_W = $bits(hc_ctl_t);
  localparam hc_ctl_t CTL_RESET = hc_ctl_t'({1'b1, {(CTL_W-1){1'b0}}});
endpackage

// File: rtl/scif_hc_latch.sv
module scif_hc_latch
  import scif_hc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sel,
  input  hc_ctl_t ctl_i,
  output hc_ctl_t ctl_o
);
  hc_ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (sel) ctl_d = ctl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RESET;
    else        ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;

  AST_HOLD_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> $stable(ctl_o)); // R1
endmodule

// File: rtl/scif_hc_presync.sv
module scif_hc_presync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_hi,
  input  logic raw_lo_n,
  output logic present
);
  logic [STAGES-1:0] sh_hi, sh_lo;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic nxt_hi, nxt_lo;
    if (i == 0) begin : g_first
      assign nxt_hi = raw_hi;
      assign nxt_lo = ~raw_lo_n;
    end else begin : g_next
      assign nxt_hi = sh_hi[i-1];
      assign nxt_lo = sh_lo[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_hi[i] <= 1'b0;
        sh_lo[i] <= 1'b0;
      end else begin
        sh_hi[i] <= nxt_hi;
        sh_lo[i] <= nxt_lo;
      end
    end
  end

  assign present = sh_hi[STAGES-1] | sh_lo[STAGES-1];
endmodule

// File: rtl/scif_hc_stab.sv
module scif_hc_stab #(
  parameter int CYCLES = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic busy
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (hold) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

  AST_STAB_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R7
  AST_STAB_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> busy); // R7
endmodule

// File: rtl/scif_hc_session.sv
module scif_hc_session (
  input  logic clk,
  input  logic rst_n,
  input  logic act_n,
  input  logic pd_req,
  input  logic card,
  input  logic settling,
  input  logic fault_in,
  output logic pd_o,
  output logic start_o,
  output logic in_sess_o,
  output logic flt_o
);
  logic pd_q, pd_d;
  logic prev_q;
  logic sess_q, sess_d;
  logic flt_q, flt_d;
  logic start;

  assign start = prev_q & ~act_n & ~pd_q & ~settling & card & ~sess_q;

  always_comb begin
    pd_d = pd_q;
    if (pd_q)                         pd_d = pd_req;
    else if (pd_req && act_n && !sess_q) pd_d = 1'b1;

    sess_d = sess_q;
    if (act_n)      sess_d = 1'b0;
    else if (start) sess_d = 1'b1;

    flt_d = flt_q;
    if (act_n)                             flt_d = 1'b0;
    else if (sess_q && (fault_in || !card)) flt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q   <= 1'b0;
      prev_q <= 1'b1;
      sess_q <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      pd_q   <= pd_d;
      prev_q <= act_n;
      sess_q <= sess_d;
      flt_q  <= flt_d;
    end
  end

  assign pd_o      = pd_q;
  assign start_o   = start;
  assign in_sess_o = sess_q;
  assign flt_o     = flt_q;

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q && !act_n |=> flt_q); // R4
  AST_PD_OUTSIDE_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> !sess_q); // R5
  AST_RELEASE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    act_n |=> !sess_q && !flt_q); // R9
endmodule

// File: rtl/scif_host_ctrl.sv
module scif_host_ctrl
  import scif_hc_pkg::*;
#(
  parameter int STAB_CYCLES = 15000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       act_n,
  input  logic       rst_req,
  input  logic       volt_sel,
  input  logic [1:0] div_sel,
  input  logic       sync_mode,
  input  logic       pd_req,
  input  logic       pres_hi,
  input  logic       pres_lo_n,
  input  logic       sess_fault,
  output logic       lat_act_n,
  output logic       lat_rst_req,
  output logic       lat_volt_sel,
  output logic [1:0] lat_div_sel,
  output logic       lat_sync_mode,
  output logic       act_start,
  output logic       sess_run,
  output logic       int_n,
  output logic       int_oe,
  output logic       host_dat_en,
  output logic       pd_state
);
  hc_ctl_t ctl_in, ctl_lat;
  logic    card, busy, in_sess, flt;

  assign ctl_in = '{act_n: act_n, rst_req: rst_req, volt_sel: volt_sel,
                    div_sel: div_sel, sync_mode: sync_mode, pd_req: pd_req};

  scif_hc_latch u_latch (
    .clk(clk), .rst_n(rst_n), .sel(cs), .ctl_i(ctl_in), .ctl_o(ctl_lat)
  );

  scif_hc_presync #(.STAGES(SYNC_STAGES)) u_pres (
    .clk(clk), .rst_n(rst_n), .raw_hi(pres_hi), .raw_lo_n(pres_lo_n), .present(card)
  );

  scif_hc_stab #(.CYCLES(STAB_CYCLES)) u_stab (
    .clk(clk), .rst_n(rst_n), .hold(pd_state), .busy(busy)
  );

  scif_hc_session u_sess (
    .clk(clk), .rst_n(rst_n), .act_n(ctl_lat.act_n), .pd_req(ctl_lat.pd_req),
    .card(card), .settling(busy), .fault_in(sess_fault),
    .pd_o(pd_state), .start_o(act_start), .in_sess_o(in_sess), .flt_o(flt)
  );

  assign lat_act_n     = ctl_lat.act_n;
  assign lat_rst_req   = ctl_lat.rst_req;
  assign lat_volt_sel  = ctl_lat.volt_sel;
  assign lat_div_sel   = ctl_lat.div_sel;
  assign lat_sync_mode = ctl_lat.sync_mode;

  assign sess_run    = in_sess & ~flt;
  assign int_n       = in_sess ? ~flt : (card & (pd_state | ~busy));
  assign int_oe      = cs;
  assign host_dat_en = cs;

  AST_START_OPENS_SESSION: assert property (@(posedge clk) disable iff (!rst_n)
    act_start |=> sess_run); // R8
  AST_RUN_KEEPS_INT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sess_run |-> int_n); // R4
  AST_NO_START_SETTLING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !act_start); // R8
endmodule

// File: tb/tb_scif_host_ctrl.sv
`timescale 1ns/100ps
module tb_scif_host_ctrl;
  localparam int STAB = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b1, act_n = 1'b1, rst_req = 1'b0, volt_sel = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic sync_mode = 1'b0, pd_req = 1'b0, pres_hi = 1'b0, pres_lo_n = 1'b1, sess_fault = 1'b0;
  logic lat_act_n, lat_rst_req, lat_volt_sel, lat_sync_mode;
  logic [1:0] lat_div_sel;
  logic act_start, sess_run, int_n, int_oe, host_dat_en, pd_state;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scif_host_ctrl #(.STAB_CYCLES(STAB)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .act_n(act_n), .rst_req(rst_req),
    .volt_sel(volt_sel), .div_sel(div_sel), .sync_mode(sync_mode), .pd_req(pd_req),
    .pres_hi(pres_hi), .pres_lo_n(pres_lo_n), .sess_fault(sess_fault),
    .lat_act_n(lat_act_n), .lat_rst_req(lat_rst_req), .lat_volt_sel(lat_volt_sel),
    .lat_div_sel(lat_div_sel), .lat_sync_mode(lat_sync_mode), .act_start(act_start),
    .sess_run(sess_run), .int_n(int_n), .int_oe(int_oe), .host_dat_en(host_dat_en),
    .pd_state(pd_state)
  );

  // Reference model built from the requirements
  logic [6:0] m_lat;
  logic [1:0] m_s1, m_s2;
  logic m_pd, m_busy, m_prev, m_sess, m_flt;
  int   m_cnt;

  function automatic logic f_card(input logic [1:0] s2);
    return s2[1] | s2[0];
  endfunction
  function automatic logic f_start(input logic prev, input logic la, input logic pd,
                                   input logic bsy, input logic cd, input logic ss);
    return prev & ~la & ~pd & ~bsy & cd & ~ss;
  endfunction
  function automatic logic f_int(input logic ss, input logic fl, input logic cd,
                                 input logic pd, input logic bsy);
    return ss ? ~fl : (cd & (pd | ~bsy));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lat <= 7'b1000000; m_s1 <= 2'b00; m_s2 <= 2'b00;
      m_pd <= 1'b0; m_busy <= 1'b1; m_cnt <= 0; m_prev <= 1'b1;
      m_sess <= 1'b0; m_flt <= 1'b0;
    end else begin
      if (cs) m_lat <= {act_n, rst_req, volt_sel, div_sel, sync_mode, pd_req};
      m_s1 <= {pres_hi, ~pres_lo_n};
      m_s2 <= m_s1;
      if (m_pd) m_pd <= m_lat[0];
      else if (m_lat[0] && m_lat[6] && !m_sess) m_pd <= 1'b1;
      if (m_pd) begin m_cnt <= 0; m_busy <= 1'b1; end
      else if (m_busy) begin
        if (m_cnt == STAB-1) m_busy <= 1'b0; else m_cnt <= m_cnt + 1;
      end
      m_prev <= m_lat[6];
      if (m_lat[6]) m_sess <= 1'b0;
      else if (f_start(m_prev, m_lat[6], m_pd, m_busy, f_card(m_s2), m_sess)) m_sess <= 1'b1;
      if (m_lat[6]) m_flt <= 1'b0;
      else if (m_sess && (sess_fault || !f_card(m_s2))) m_flt <= 1'b1;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 latched controls", {1'b0, lat_act_n, lat_rst_req, lat_volt_sel, lat_div_sel, lat_sync_mode}, {2'b00, m_lat[6:1]});
      chk("R2 output enables", {6'd0, int_oe, host_dat_en}, {6'd0, cs, cs});
      chk("R3 int_n", {7'd0, int_n}, {7'd0, f_int(m_sess, m_flt, f_card(m_s2), m_pd, m_busy)});
      chk("R5 pd_state", {7'd0, pd_state}, {7'd0, m_pd});
      chk("R8 act_start", {7'd0, act_start}, {7'd0, f_start(m_prev, m_lat[6], m_pd, m_busy, f_card(m_s2), m_sess)});
      chk("R4 sess_run", {7'd0, sess_run}, {7'd0, m_sess & ~m_flt});
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R10 reset state
    chk("R10 reset latched act", {7'd0, lat_act_n}, 8'd1);
    chk("R10 reset others", {4'd0, lat_rst_req, lat_volt_sel, pd_state, sess_run}, 8'd0);
    pres_hi = 1'b1; step(10);
    chk("R7 int low while settling", {7'd0, int_n}, 8'd0);
    step(50);
    chk("R3 card present int high", {7'd0, int_n}, 8'd1);
    sess_fault = 1'b1; step(2);
    chk("R3 fault ignored outside session", {7'd0, int_n}, 8'd1);
    sess_fault = 1'b0;
    act_n = 1'b0; step(5);
    chk("R8 session opened", {7'd0, sess_run}, 8'd1);
    pd_req = 1'b1; step(5);
    chk("R5 pd ignored in session", {7'd0, pd_state}, 8'd0);
    pd_req = 1'b0;
    sess_fault = 1'b1; step(1); sess_fault = 1'b0; step(2);
    chk("R4 fault drops int", {6'd0, int_n, sess_run}, 8'd0);
    step(5);
    chk("R4 fault held", {6'd0, int_n, sess_run}, 8'd0);
    act_n = 1'b1; step(3);
    chk("R9 release clears fault", {7'd0, int_n}, 8'd1);
    cs = 1'b0; act_n = 1'b0; volt_sel = 1'b1; #1;
    chk("R2 deselected enables", {6'd0, int_oe, host_dat_en}, 8'd0);
    step(3);
    chk("R1 frozen while deselected", {6'd0, lat_act_n, lat_volt_sel}, 8'b10);
    cs = 1'b1; step(2);
    chk("R1 pass after select", {7'd0, lat_volt_sel}, 8'd1);
    act_n = 1'b1; step(3);
    pd_req = 1'b1; step(3);
    chk("R5 pd entered", {7'd0, pd_state}, 8'd1);
    pres_hi = 1'b0; step(4);
    chk("R6 pd no card", {7'd0, int_n}, 8'd0);
    pres_hi = 1'b1; step(4);
    chk("R6 pd card inserted", {7'd0, int_n}, 8'd1);
    act_n = 1'b0; step(4);
    chk("R8 edge ignored in pd", {7'd0, sess_run}, 8'd0);
    pd_req = 1'b0; step(10);
    chk("R7 settling after pd exit", {7'd0, int_n}, 8'd0);
    step(50);
    chk("R8 stale edge not used", {6'd0, sess_run, int_n}, 8'b01);
    act_n = 1'b1; step(3); act_n = 1'b0; step(4);
    chk("R8 fresh edge opens", {7'd0, sess_run}, 8'd1);
    pres_hi = 1'b0; step(5);
    chk("R4 card removal fault", {6'd0, int_n, sess_run}, 8'd0);
    act_n = 1'b1; step(3);
    pres_lo_n = 1'b0; step(4);
    chk("R3 active-low switch", {7'd0, int_n}, 8'd1);
    pres_lo_n = 1'b1; step(4);

    for (int i = 0; i < 6000; i++) begin
      cs        = ($urandom % 8) != 0;
      rst_req   = $urandom % 2;
      volt_sel  = $urandom % 2;
      div_sel   = 2'($urandom % 4);
      sync_mode = $urandom % 2;
      if ($urandom % 20 == 0) act_n = ~act_n;
      if ($urandom % 97 == 0) pd_req = ~pd_req;
      if ($urandom % 50 == 0) pres_hi = ~pres_hi;
      if ($urandom % 70 == 0) pres_lo_n = ~pres_lo_n;
      sess_fault = ($urandom % 40) == 0;
      step(1);
    end
    step(1);
    finish_run();
  end
endmodule